// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller. Pins are grouped into banks of 16. Each 32-bit register word covers one pair of banks: bits 15..0 hold the even bank and bits 31..16 hold the odd bank. For every pin the controller stores a direction bit and an output value. Software can change the output value three ways: by a direct write, by a set-only write, or by a clear-only write. Pin inputs pass through a synchronizer before the block reads them back or looks for edges.

Edge detection compares each synchronized input with its value on the previous clock. Each pin has a rising-edge enable and a falling-edge enable. Each enable is changed only through its own set-only and clear-only words, so software never needs a read-modify-write. An enabled edge latches a per-pin status flag, and software clears the flag by writing 1 to it. Each bank drives one interrupt line. That line is high while the bank's enable bit is set and any status flag in the bank is pending. The controller has two resets: an asynchronous hardware reset and a synchronous software reset. Both return every register to its default.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After hardware reset, `pin_oe`, `pin_out` and `bank_irq` are all zero, and every readable register word reads 0.
- R2: Word 0 holds the bank interrupt enables, with bit b for bank b. Pair p (banks 2p and 2p+1) uses word base 16*(p+1), with these offsets: +0 direction, +1 output data, +2 output set, +3 output clear, +4 input, +5 rising set, +6 rising clear, +7 falling set, +8 falling clear, +9 status. A direction bit of 1 makes its pin an output, so `pin_oe` for that pin goes high on the clock edge that takes the write.
- R3: A write to the output data word replaces the output value of all 32 pins of the pair on `pin_out`, effective from the next clock edge.
- R4: A write to the output set word sets the output bits where the write data is 1, and a write to the output clear word clears them. Bits written 0 are left unchanged. Reading either word returns the current output value.
- R5: The input word reports `pin_in` after two synchronizing flops. A pin change made before clock edge k first reads back after edge k+1.
- R6: Writing 1s to the rising-set word enables rising-edge detection on those pins, and writing 1s to the rising-clear word disables it. Bits written 0 have no effect. Reading either word returns the current rising enables.
- R7: The falling-edge enables behave the same way through the falling-set and falling-clear words. A pin whose falling enable is 0 records no status on a falling edge.
- R8: An enabled edge sets the pin's status bit. A pin change made before edge k shows in the status word after edge k+2. Edges are detected on pins configured as outputs too.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new enabled edge arrives in the same cycle as the clear, the bit stays set.
- R10: `bank_irq[b]` is high exactly when bank enable b is 1 and at least one status bit of bank b is set. Turning the enable on while a status bit is already pending raises the line on the next cycle.
- R11: One cycle of `sw_rst` returns direction, output data, edge enables, status and bank enables to 0, the same as hardware reset.
- R12: A pin with both enables set records status on a rising edge and on a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous active-high software reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from `bus_addr`) |
| pin_in | input | NUM_BANKS*16 | Raw pin inputs |
| pin_out | output | NUM_BANKS*16 | Output values |
| pin_oe | output | NUM_BANKS*16 | Output enables (1 = pin driven) |
| bank_irq | output | NUM_BANKS | Per-bank interrupt lines |

## Verification
A corrupted output or direction register appears on `pin_out` or `pin_oe` in the cycle after the offending write, so the bench checks those vectors right after each set, clear and direct write. A wrong enable or edge-detect state shows only through the status word and `bank_irq`, two clocks after the pin change. The bench therefore reads status both one cycle early, when it must still be 0, and on the expected cycle. A lost clear-versus-edge priority leaves a bit at 0 that must stay 1, and the bench catches it with a clear deliberately timed to coincide with an edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W = 32;
  localparam int BANK_W = 16;
  localparam int GRP_STRIDE = 16;

  typedef enum logic [3:0] {
    OFS_DIR  = 4'd0,
    OFS_OUT  = 4'd1,
    OFS_SET  = 4'd2,
    OFS_CLR  = 4'd3,
    OFS_IN   = 4'd4,
    OFS_RSET = 4'd5,
    OFS_RCLR = 4'd6,
    OFS_FSET = 4'd7,
    OFS_FCLR = 4'd8,
    OFS_STAT = 4'd9
  } reg_ofs_e;

  // word address of a register inside the group of one bank pair
  function automatic int word_addr(input int pair, input reg_ofs_e ofs);
    return (pair + 1) * GRP_STRIDE + int'(ofs);
  endfunction

  // pins whose enabled transition occurred this cycle
  function automatic logic [WORD_W-1:0] edge_hits(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] prev,
                                                  input logic [WORD_W-1:0] ren,
                                                  input logic [WORD_W-1:0] fen);
    return (cur & ~prev & ren) | (~cur & prev & fen);
  endfunction

  // write-one-to-clear with new events winning
  function automatic logic [WORD_W-1:0] next_status(input logic [WORD_W-1:0] stat,
                                                    input logic [WORD_W-1:0] clr,
                                                    input logic [WORD_W-1:0] hit);
    return (stat & ~clr) | hit;
  endfunction

  // apply set-only or clear-only masks
  function automatic logic [WORD_W-1:0] apply_masks(input logic [WORD_W-1:0] val,
                                                    input logic [WORD_W-1:0] set_m,
                                                    input logic [WORD_W-1:0] clr_m);
    return (val | set_m) & ~clr_m;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else if (sw_rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_pair_regs.sv
module gpio_pair_regs
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PAIR_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] sync_in,
  output logic [WORD_W-1:0] dir_q,
  output logic [WORD_W-1:0] out_q,
  output logic [WORD_W-1:0] stat_q,
  output logic [WORD_W-1:0] hit,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] prev_q, ren_q, fen_q;

  function automatic logic at(input logic [ADDR_W-1:0] a, input reg_ofs_e o);
    return a == ADDR_W'(word_addr(PAIR_IDX, o));
  endfunction

  logic wr_dir, wr_out, wr_set, wr_clr, wr_rset, wr_rclr, wr_fset, wr_fclr, wr_stat;
  assign wr_dir  = bus_we && at(bus_addr, OFS_DIR);
  assign wr_out  = bus_we && at(bus_addr, OFS_OUT);
  assign wr_set  = bus_we && at(bus_addr, OFS_SET);
  assign wr_clr  = bus_we && at(bus_addr, OFS_CLR);
  assign wr_rset = bus_we && at(bus_addr, OFS_RSET);
  assign wr_rclr = bus_we && at(bus_addr, OFS_RCLR);
  assign wr_fset = bus_we && at(bus_addr, OFS_FSET);
  assign wr_fclr = bus_we && at(bus_addr, OFS_FCLR);
  assign wr_stat = bus_we && at(bus_addr, OFS_STAT);

  assign hit = edge_hits(sync_in, prev_q, ren_q, fen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      stat_q <= '0;
    end else if (sw_rst) begin
      prev_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= sync_in;
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_out) out_q <= bus_wdata;
      else        out_q <= apply_masks(out_q, wr_set ? bus_wdata : '0,
                                       wr_clr ? bus_wdata : '0);
      ren_q  <= apply_masks(ren_q, wr_rset ? bus_wdata : '0, wr_rclr ? bus_wdata : '0);
      fen_q  <= apply_masks(fen_q, wr_fset ? bus_wdata : '0, wr_fclr ? bus_wdata : '0);
      stat_q <= next_status(stat_q, wr_stat ? bus_wdata : '0, hit);
    end
  end

  always_comb begin
    rdata = '0;
    if (at(bus_addr, OFS_DIR))                                 rdata = dir_q;
    if (at(bus_addr, OFS_OUT) || at(bus_addr, OFS_SET) ||
        at(bus_addr, OFS_CLR))                                 rdata = out_q;
    if (at(bus_addr, OFS_IN))                                  rdata = sync_in;
    if (at(bus_addr, OFS_RSET) || at(bus_addr, OFS_RCLR))      rdata = ren_q;
    if (at(bus_addr, OFS_FSET) || at(bus_addr, OFS_FCLR))      rdata = fen_q;
    if (at(bus_addr, OFS_STAT))                                rdata = stat_q;
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sw_rst,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
  output logic [NUM_BANKS*BANK_W-1:0] pin_out,
  output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
  output logic [NUM_BANKS-1:0]        bank_irq
);

  localparam int NPIN  = NUM_BANKS * BANK_W;
  localparam int NPAIR = NUM_BANKS / 2;

  // named internal events for the checker
  logic [NPIN-1:0]      sync_all;
  logic [NPIN-1:0]      evt_all;
  logic [NPIN-1:0]      stat_all;
  logic [NUM_BANKS-1:0] bank_en_q;
  logic [WORD_W-1:0]    rd_pair [NPAIR];

  gpio_in_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .d(pin_in), .q(sync_all)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    gpio_pair_regs #(.ADDR_W(ADDR_W), .PAIR_IDX(p)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_rst   (sw_rst),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .sync_in  (sync_all[p*WORD_W +: WORD_W]),
      .dir_q    (pin_oe[p*WORD_W +: WORD_W]),
      .out_q    (pin_out[p*WORD_W +: WORD_W]),
      .stat_q   (stat_all[p*WORD_W +: WORD_W]),
      .hit      (evt_all[p*WORD_W +: WORD_W]),
      .rdata    (rd_pair[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      bank_en_q <= '0;
    else if (sw_rst)                 bank_en_q <= '0;
    else if (bus_we && bus_addr == '0) bank_en_q <= bus_wdata[NUM_BANKS-1:0];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
    assign bank_irq[b] = bank_en_q[b] & (|stat_all[b*BANK_W +: BANK_W]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata[NUM_BANKS-1:0] = bank_en_q;
    for (int p = 0; p < NPAIR; p++) bus_rdata = bus_rdata | rd_pair[p];
  end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sw_rst,
  input logic                        bus_we,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [WORD_W-1:0]           bus_wdata,
  input logic [NUM_BANKS*BANK_W-1:0] pin_out,
  input logic [NUM_BANKS*BANK_W-1:0] pin_oe,
  input logic [NUM_BANKS-1:0]        bank_irq,
  input logic [NUM_BANKS*BANK_W-1:0] evt_all,
  input logic [NUM_BANKS*BANK_W-1:0] stat_all
);

  localparam int NPAIR = NUM_BANKS / 2;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pchk
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(word_addr(p, OFS_DIR));
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(word_addr(p, OFS_SET));
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(word_addr(p, OFS_CLR));
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(word_addr(p, OFS_STAT));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DIR && !sw_rst) |=> pin_oe[p*WORD_W +: WORD_W] == $past(bus_wdata));

    // R4
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_SET && !sw_rst) |=>
        pin_out[p*WORD_W +: WORD_W] == ($past(pin_out[p*WORD_W +: WORD_W]) | $past(bus_wdata)));

    // R4
    clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_CLR && !sw_rst) |=>
        pin_out[p*WORD_W +: WORD_W] == ($past(pin_out[p*WORD_W +: WORD_W]) & ~$past(bus_wdata)));

    // R9
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_we && bus_addr == A_STAT) && !sw_rst) |=>
        (stat_all[p*WORD_W +: WORD_W] & $past(stat_all[p*WORD_W +: WORD_W])) ==
          $past(stat_all[p*WORD_W +: WORD_W]));
  end

  // R8
  stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_all & ~$past(stat_all) & ~$past(evt_all)) == '0);

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (pin_oe == '0 && pin_out == '0 && bank_irq == '0));

endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq),
  .evt_all(evt_all), .stat_all(stat_all)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;

  localparam int NB = 4;
  localparam int AW = 8;
  localparam int NP = NB * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_rst = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NB-1:0] bank_irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .bank_irq(bank_irq)
  );

  // register map as stated in R2
  function automatic int ra(input int pair, input int ofs);
    return 16 * pair + 16 + ofs;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdc(input string tag, input int a, input logic [31:0] exp);
    bus_addr = AW'(a);
    #1;
    chk(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic t_reset;
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 bank_irq", 64'(bank_irq), 0);
    rdc("R1 bank enable word", 0, 0);
    rdc("R1 rising enables", ra(0, 5), 0);
    rdc("R1 status", ra(1, 9), 0);
  endtask

  task automatic t_dir;
    wr(ra(0, 0), 32'h8001_0003);
    wr(ra(1, 0), 32'hFFFF_0000);
    chk("R2 pin_oe both pairs", pin_oe, 64'hFFFF_0000_8001_0003);
    rdc("R2 dir readback", ra(1, 0), 32'hFFFF_0000);
  endtask

  task automatic t_out;
    wr(ra(0, 1), 32'hA5A5_5A5A);
    wr(ra(1, 1), 32'h1234_5678);
    chk("R3 pin_out", pin_out, 64'h1234_5678_A5A5_5A5A);
  endtask

  task automatic t_setclr;
    wr(ra(0, 2), 32'h0000_00F0);
    chk("R4 set", pin_out[31:0], 64'hA5A5_5AFA);
    wr(ra(0, 3), 32'hA000_0000);
    chk("R4 clear", pin_out[31:0], 64'h05A5_5AFA);
    wr(ra(0, 2), 32'h0);
    wr(ra(0, 3), 32'h0);
    chk("R4 zero writes ignored", pin_out, 64'h1234_5678_05A5_5AFA);
    rdc("R4 set word reads output", ra(0, 2), 32'h05A5_5AFA);
    rdc("R4 clear word reads output", ra(0, 3), 32'h05A5_5AFA);
  endtask

  task automatic t_input;
    pin_in[40] = 1'b1;
    tick(1);
    rdc("R5 input after one edge", ra(1, 4), 32'h0);
    tick(1);
    rdc("R5 input after two edges", ra(1, 4), 32'h0000_0100);
    pin_in[40] = 1'b0;
    tick(3);
  endtask

  task automatic t_trig;
    wr(ra(0, 5), 32'h11);
    wr(ra(0, 5), 32'h100);
    rdc("R6 rising set accumulates", ra(0, 5), 32'h111);
    wr(ra(0, 6), 32'h10);
    wr(ra(0, 6), 32'h0);
    rdc("R6 rising clear", ra(0, 6), 32'h101);
    wr(ra(0, 6), 32'hFFFF_FFFF);
    rdc("R6 rising all cleared", ra(0, 5), 32'h0);
    wr(ra(0, 7), 32'h4);
    wr(ra(0, 7), 32'h8);
    wr(ra(0, 8), 32'h8);
    rdc("R7 falling set word", ra(0, 7), 32'h4);
    rdc("R7 falling clear word", ra(0, 8), 32'h4);
    wr(ra(0, 5), 32'h5);
  endtask

  task automatic t_edge;
    // pin 0 is configured as an output here
    pin_in[0] = 1'b1;
    tick(2);
    rdc("R8 status not yet set", ra(0, 9), 32'h0);
    tick(1);
    rdc("R8 status set on rising edge", ra(0, 9), 32'h1);
    wr(ra(0, 9), 32'h1);
    rdc("R9 write one clears", ra(0, 9), 32'h0);
    pin_in[0] = 1'b0;
    tick(4);
    rdc("R7 falling edge without enable", ra(0, 9), 32'h0);
  endtask

  task automatic t_both;
    pin_in[2] = 1'b1;
    tick(3);
    rdc("R12 rising on both-edge pin", ra(0, 9), 32'h4);
    wr(ra(0, 9), 32'h4);
    pin_in[2] = 1'b0;
    tick(3);
    rdc("R12 falling on both-edge pin", ra(0, 9), 32'h4);
  endtask

  task automatic t_irq;
    chk("R10 gated while bank disabled", 64'(bank_irq), 0);
    wr(0, 32'h1);
    chk("R10 enable with pending status", 64'(bank_irq), 64'h1);
    wr(ra(0, 9), 32'h4);
    chk("R10 drops after clear", 64'(bank_irq), 0);
    wr(ra(1, 5), 32'h8000_0000);
    pin_in[63] = 1'b1;
    tick(3);
    rdc("R8 status bank 3", ra(1, 9), 32'h8000_0000);
    chk("R10 bank 3 disabled", 64'(bank_irq), 0);
    wr(0, 32'h9);
    chk("R10 bank 3 enabled", 64'(bank_irq), 64'h8);
    wr(ra(1, 9), 32'h8000_0000);
    chk("R10 bank 3 cleared", 64'(bank_irq), 0);
  endtask

  task automatic t_prio;
    pin_in[2] = 1'b1;
    tick(3);
    wr(ra(0, 9), 32'h0);
    rdc("R9 zero write keeps status", ra(0, 9), 32'h4);
    pin_in[2] = 1'b0;
    tick(2);
    wr(ra(0, 9), 32'h4);
    rdc("R9 edge beats clear", ra(0, 9), 32'h4);
    chk("R10 irq held", 64'(bank_irq), 64'h1);
    wr(ra(0, 9), 32'h4);
    rdc("R9 clear without edge", ra(0, 9), 32'h0);
  endtask

  task automatic t_swrst;
    pin_in[2] = 1'b1;
    tick(3);
    chk("R10 irq before soft reset", 64'(bank_irq), 64'h1);
    sw_rst = 1'b1;
    tick(1);
    sw_rst = 1'b0;
    chk("R11 pin_oe", pin_oe, '0);
    chk("R11 pin_out", pin_out, '0);
    chk("R11 bank_irq", 64'(bank_irq), 0);
    rdc("R11 bank enables", 0, 0);
    rdc("R11 rising enables", ra(0, 5), 0);
    rdc("R11 falling enables", ra(0, 7), 0);
    rdc("R11 status", ra(0, 9), 0);
    tick(4);
    rdc("R11 no status after reset", ra(0, 9), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_dir();
    t_out();
    t_setclr();
    t_input();
    t_trig();
    t_edge();
    t_both();
    t_irq();
    t_prio();
    t_swrst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule